// File: doc/BRIEF.md
# Four-Input Fragment Merger

This block gathers one fragment from each of four 32-bit word-stream inputs and emits them as a single event package on one 32-bit output stream. Every input and the output use a valid/ready handshake with a per-word control flag. The package opens with two merger header words. It then carries the fragment of input 1 word by word, followed by an end-of-fragment marker word. The same follows for inputs 2, 3 and 4 in turn. A merger trailer closes the package.

Words are passed straight through while they arrive, so the output never waits for a whole fragment to be received. Only the input being served sees ready high. A stalled output holds that input back without losing words. When the trailer has been sent, the block goes idle. It opens the next package only when input 1 offers a word again.

Top module: `slink_frag_merger`

## Requirements
- R1: After reset, out_valid is low and all in_ready bits are low.
- R2: While idle, the block emits nothing until input 1 (bit 0) raises in_valid. Valid words on inputs 2 to 4 alone start no package.
- R3: The first output word is merger header 1 = {HDR_TAG[15:0], NUM_IN[15:0]} (default HDR_TAG 0xB0A1). The second is merger header 2 = a package sequence number that is 0 for the first package after reset and rises by 1 per package. Both carry out_ctrl = 1.
- R4: Each input word is forwarded unchanged, with its own control flag, in arrival order. An input's fragment ends with its word that has in_ctrl = 1.
- R5: After each fragment's last word, the block emits the marker word 0xE0F00000 with out_ctrl = 1.
- R6: Fragments appear in input order 1, 2, 3, 4. At most one in_ready bit is high, and only for the input being served. Other inputs wait.
- R7: While out_ready is low, no in_ready bit is high and a valid output word stays unchanged. No word is dropped or duplicated.
- R8: The last word is the merger trailer = {TRL_TAG[15:0], err, 7'b0, count[7:0]} with out_ctrl = 1 (default TRL_TAG 0xB0AF). count is the number of fragments received (4). err is the OR of bit 0 of every fragment's last word.
- R9: After the trailer the block is idle. A new package starts only when input 1 presents a new fragment, even if the other inputs are already loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | NUM_IN*DW | Input words, input k in bits [k*DW +: DW] |
| in_ctrl | input | NUM_IN | Per-input control flag; 1 marks the fragment's last word |
| in_valid | input | NUM_IN | Per-input word valid |
| in_ready | output | NUM_IN | Per-input ready, high only for the served input |
| out_data | output | DW | Package output word |
| out_ctrl | output | 1 | Output control flag |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output ready from the downstream link |

## Verification
The merge is exercised with fragments of different lengths, including a single-word fragment. It is also exercised with an input that is loaded before its turn, and with inputs 2 to 4 loaded while input 1 stays empty. Each of these shows whether the fixed order and the input-1 start condition hold. A pseudo-random out_ready pattern tells correct backpressure apart from lost or repeated words. An error bit set in only one input's last word shows whether it reaches the trailer flag. Three packages in a row check that the sequence number advances.

// File: rtl/slm_pkg.sv
package slm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR1,
      ST_HDR2,
      ST_PASS,
      ST_MARK,
      ST_TRL
   } slm_state_e;

   localparam logic [31:0] FRAG_END_MARK = 32'hE0F0_0000;
endpackage

// File: rtl/slm_in_select.sv
module slm_in_select #(
   parameter int NUM_IN = 4,
   parameter int DW     = 32,
   parameter int SEL_W  = 2
) (
   input  logic [NUM_IN*DW-1:0] in_data,
   input  logic [NUM_IN-1:0]    in_ctrl,
   input  logic [NUM_IN-1:0]    in_valid,
   input  logic [SEL_W-1:0]     sel,
   input  logic                 pass_en,
   output logic [DW-1:0]        cur_data,
   output logic                 cur_ctrl,
   output logic                 cur_valid,
   output logic [NUM_IN-1:0]    in_ready
);
   for (genvar g = 0; g < NUM_IN; g++) begin : g_rdy
      assign in_ready[g] = pass_en && (sel == SEL_W'(g));
   end

   always_comb begin
      cur_data  = '0;
      cur_ctrl  = 1'b0;
      cur_valid = 1'b0;
      for (int k = 0; k < NUM_IN; k++) begin
         if (sel == SEL_W'(k)) begin
            cur_data  = in_data[k*DW +: DW];
            cur_ctrl  = in_ctrl[k];
            cur_valid = in_valid[k];
         end
      end
   end
endmodule

// File: rtl/slm_seq_ctrl.sv
module slm_seq_ctrl
   import slm_pkg::*;
#(
   parameter int NUM_IN = 4,
   parameter int DW     = 32,
   parameter int SEL_W  = 2,
   parameter int CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cur_valid,
   input  logic             cur_ctrl,
   input  logic             cur_err,
   input  logic             out_ready,
   output slm_state_e       state,
   output logic [SEL_W-1:0] sel,
   output logic             err_seen,
   output logic [CNT_W-1:0] frag_cnt,
   output logic [DW-1:0]    pkt_seq
);
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_IN - 1);

   logic hs_in;
   assign hs_in = (state == ST_PASS) && cur_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sel      <= '0;
         err_seen <= 1'b0;
         frag_cnt <= '0;
         pkt_seq  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) state <= ST_HDR1;
            ST_HDR1: if (out_ready) state <= ST_HDR2;
            ST_HDR2: if (out_ready) state <= ST_PASS;
            ST_PASS: begin
               if (hs_in && cur_ctrl) begin
                  state    <= ST_MARK;
                  frag_cnt <= frag_cnt + 1'b1;
                  err_seen <= err_seen | cur_err;
               end
            end
            ST_MARK: begin
               if (out_ready) begin
                  if (sel == LAST_SEL) begin
                     state <= ST_TRL;
                  end else begin
                     sel   <= sel + 1'b1;
                     state <= ST_PASS;
                  end
               end
            end
            ST_TRL: begin
               if (out_ready) begin
                  state    <= ST_IDLE;
                  sel      <= '0;
                  err_seen <= 1'b0;
                  frag_cnt <= '0;
                  pkt_seq  <= pkt_seq + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_IDLE_WAITS_IN1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start) |=> (state == ST_IDLE)); // R2
   AST_END_THEN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_in && cur_ctrl) |=> (state == ST_MARK)); // R5
   AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MARK && out_ready && sel != LAST_SEL) |=> (sel == $past(sel) + 1'b1)); // R6
   AST_TRL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRL) |-> (frag_cnt == CNT_W'(NUM_IN))); // R8
endmodule

// File: rtl/slm_word_build.sv
module slm_word_build
   import slm_pkg::*;
#(
   parameter int          NUM_IN  = 4,
   parameter int          DW      = 32,
   parameter int          CNT_W   = 3,
   parameter logic [15:0] HDR_TAG = 16'hB0A1,
   parameter logic [15:0] TRL_TAG = 16'hB0AF
) (
   input  slm_state_e       state,
   input  logic [DW-1:0]    cur_data,
   input  logic             cur_ctrl,
   input  logic             cur_valid,
   input  logic             err_seen,
   input  logic [CNT_W-1:0] frag_cnt,
   input  logic [DW-1:0]    pkt_seq,
   output logic [DW-1:0]    out_data,
   output logic             out_ctrl,
   output logic             out_valid
);
   always_comb begin
      out_data  = '0;
      out_ctrl  = 1'b0;
      out_valid = 1'b0;
      unique case (state)
         ST_HDR1: begin
            out_data  = {HDR_TAG, 16'(NUM_IN)};
            out_ctrl  = 1'b1;
            out_valid = 1'b1;
         end
         ST_HDR2: begin
            out_data  = pkt_seq;
            out_ctrl  = 1'b1;
            out_valid = 1'b1;
         end
         ST_PASS: begin
            out_data  = cur_data;
            out_ctrl  = cur_ctrl;
            out_valid = cur_valid;
         end
         ST_MARK: begin
            out_data  = FRAG_END_MARK;
            out_ctrl  = 1'b1;
            out_valid = 1'b1;
         end
         ST_TRL: begin
            out_data  = {TRL_TAG, err_seen, 7'b0, 8'(frag_cnt)};
            out_ctrl  = 1'b1;
            out_valid = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/slink_frag_merger.sv
module slink_frag_merger
   import slm_pkg::*;
#(
   parameter int          NUM_IN  = 4,
   parameter int          DW      = 32,
   parameter logic [15:0] HDR_TAG = 16'hB0A1,
   parameter logic [15:0] TRL_TAG = 16'hB0AF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_IN*DW-1:0] in_data,
   input  logic [NUM_IN-1:0]    in_ctrl,
   input  logic [NUM_IN-1:0]    in_valid,
   output logic [NUM_IN-1:0]    in_ready,
   output logic [DW-1:0]        out_data,
   output logic                 out_ctrl,
   output logic                 out_valid,
   input  logic                 out_ready
);
   localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
   localparam int CNT_W = $clog2(NUM_IN + 1);

   if (DW != 32) begin : g_bad_dw
      $error("slink_frag_merger: DW must be 32");
   end
   if (NUM_IN < 1 || NUM_IN > 255) begin : g_bad_num
      $error("slink_frag_merger: NUM_IN must be 1..255");
   end

   slm_state_e       state;
   logic [SEL_W-1:0] sel;
   logic             err_seen;
   logic [CNT_W-1:0] frag_cnt;
   logic [DW-1:0]    pkt_seq;
   logic [DW-1:0]    cur_data;
   logic             cur_ctrl;
   logic             cur_valid;
   logic             pass_en;

   assign pass_en = (state == ST_PASS) && out_ready;

   slm_in_select #(.NUM_IN(NUM_IN), .DW(DW), .SEL_W(SEL_W)) u_sel (
      .in_data  (in_data),
      .in_ctrl  (in_ctrl),
      .in_valid (in_valid),
      .sel      (sel),
      .pass_en  (pass_en),
      .cur_data (cur_data),
      .cur_ctrl (cur_ctrl),
      .cur_valid(cur_valid),
      .in_ready (in_ready)
   );

   slm_seq_ctrl #(.NUM_IN(NUM_IN), .DW(DW), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (in_valid[0]),
      .cur_valid(cur_valid),
      .cur_ctrl (cur_ctrl),
      .cur_err  (cur_data[0]),
      .out_ready(out_ready),
      .state    (state),
      .sel      (sel),
      .err_seen (err_seen),
      .frag_cnt (frag_cnt),
      .pkt_seq  (pkt_seq)
   );

   slm_word_build #(.NUM_IN(NUM_IN), .DW(DW), .CNT_W(CNT_W),
                    .HDR_TAG(HDR_TAG), .TRL_TAG(TRL_TAG)) u_build (
      .state    (state),
      .cur_data (cur_data),
      .cur_ctrl (cur_ctrl),
      .cur_valid(cur_valid),
      .err_seen (err_seen),
      .frag_cnt (frag_cnt),
      .pkt_seq  (pkt_seq),
      .out_data (out_data),
      .out_ctrl (out_ctrl),
      .out_valid(out_valid)
   );

   AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready)); // R6
   AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> (in_ready == '0)); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl))); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!out_valid && in_ready == '0)); // R9
endmodule

// File: tb/slink_frag_merger_tb_top.sv
module slink_frag_merger_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          NI         = 4;
   localparam int          DWB        = 32;
   localparam int          MAXW       = 16;
   localparam logic [15:0] HTAG       = 16'hB0A1;
   localparam logic [15:0] TTAG       = 16'hB0AF;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NI*DWB-1:0]   in_data;
   logic [NI-1:0]       in_ctrl;
   logic [NI-1:0]       in_valid;
   logic [NI-1:0]       in_ready;
   logic [DWB-1:0]      out_data;
   logic                out_ctrl;
   logic                out_valid;
   logic                out_ready = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   slink_frag_merger #(.NUM_IN(NI), .DW(DWB), .HDR_TAG(HTAG), .TRL_TAG(TTAG)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
      .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
      .out_ctrl(out_ctrl), .out_valid(out_valid), .out_ready(out_ready));

   logic [32:0] mem [NI][MAXW];
   int          len [NI];
   int          idx [NI];
   logic [32:0] cap [128];
   int          ncap;
   logic [32:0] expw [128];
   string       expr [128];
   int          nexp;
   int          checks = 0;
   int          fails  = 0;
   int          viol   = 0;
   int          cyc    = 0;
   bit          rnd_rdy = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always_comb begin
      for (int i = 0; i < NI; i++) begin
         in_valid[i] = (idx[i] < len[i]);
         if (idx[i] < len[i]) begin
            in_data[i*DWB +: DWB] = mem[i][idx[i]][31:0];
            in_ctrl[i]            = mem[i][idx[i]][32];
         end else begin
            in_data[i*DWB +: DWB] = '0;
            in_ctrl[i]            = 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      for (int i = 0; i < NI; i++)
         if (in_valid[i] && in_ready[i]) idx[i] <= idx[i] + 1;
      if (rst_n && out_valid && out_ready && ncap < 128) begin
         cap[ncap] <= {out_ctrl, out_data};
         ncap      <= ncap + 1;
      end
      if (rst_n && !out_ready && (in_ready != '0)) viol <= viol + 1;
   end

   always @(negedge clk) begin
      lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= rnd_rdy ? lfsr[0] : 1'b1;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fails  = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%09h expected 0x%09h", req, what, act, exp);
      end
   endtask

   task automatic load(input int i, input int n, input bit err);
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         mem[i][k] = {1'b0, 32'h1000_0000 * (i + 1) + 32'h0001_0000 * k + 32'h0000_0A02};
         if (k == n - 1) mem[i][k] = {1'b1, mem[i][k][31:1], err};
      end
      len[i] = n;
      idx[i] <= 0;
   endtask

   task automatic build_exp(input logic [31:0] seq, input bit err);
      nexp = 0;
      expw[nexp] = {1'b1, HTAG, 16'd4};  expr[nexp] = "R3"; nexp++;
      expw[nexp] = {1'b1, seq};          expr[nexp] = "R3"; nexp++;
      for (int i = 0; i < NI; i++) begin
         for (int k = 0; k < len[i]; k++) begin
            expw[nexp] = mem[i][k]; expr[nexp] = "R4/R6"; nexp++;
         end
         expw[nexp] = {1'b1, 32'hE0F0_0000}; expr[nexp] = "R5"; nexp++;
      end
      expw[nexp] = {1'b1, TTAG, err, 7'b0, 8'd4}; expr[nexp] = "R8"; nexp++;
   endtask

   task automatic wait_and_compare(input string tag);
      int t = 0;
      while (ncap < nexp && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (4) @(negedge clk);
      chk(ncap == nexp, "R7", {tag, " word count"}, 33'(ncap), 33'(nexp));
      for (int w = 0; w < nexp; w++)
         chk(cap[w] === expw[w], expr[w], $sformatf("%s word %0d", tag, w), cap[w], expw[w]);
      chk(!out_valid && in_ready == '0, "R9", {tag, " idle after trailer"},
          {out_valid, 28'd0, in_ready}, 33'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!out_valid, "R1", "out_valid after reset", 33'(out_valid), 33'd0);
      chk(in_ready == '0, "R1", "in_ready after reset", 33'(in_ready), 33'd0);
   endtask

   task automatic t_no_start_without_in1();
      load(1, 4, 1'b0);
      repeat (10) @(negedge clk);
      chk(ncap == 0 && !out_valid, "R2", "no package from input 2 alone", 33'(ncap), 33'd0);
      chk(in_ready == '0, "R6", "input 2 held while idle", 33'(in_ready), 33'd0);
   endtask

   task automatic t_basic_package();
      ncap <= 0;
      load(2, 4, 1'b0);
      load(3, 5, 1'b0);
      load(0, 3, 1'b0);
      build_exp(32'd0, 1'b0);
      wait_and_compare("basic");
   endtask

   task automatic t_backpressure_err();
      ncap <= 0;
      viol <= 0;
      rnd_rdy = 1'b1;
      load(1, 6, 1'b0);
      load(2, 3, 1'b1);
      load(3, 4, 1'b0);
      load(0, 5, 1'b0);
      build_exp(32'd1, 1'b1);
      wait_and_compare("stall");
      chk(viol == 0, "R7", "no input taken while stalled", 33'(viol), 33'd0);
      rnd_rdy = 1'b0;
   endtask

   task automatic t_restart_on_in1();
      ncap <= 0;
      load(1, 3, 1'b0);
      load(2, 4, 1'b0);
      load(3, 1, 1'b0);
      repeat (10) @(negedge clk);
      chk(ncap == 0 && !out_valid, "R9", "no new package before input 1",
          33'(ncap), 33'd0);
      load(0, 3, 1'b0);
      build_exp(32'd2, 1'b0);
      wait_and_compare("restart");
   endtask

   initial begin
      for (int i = 0; i < NI; i++) begin
         len[i] = 0;
         idx[i] = 0;
      end
      ncap = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_no_start_without_in1();
      t_basic_package();
      t_backpressure_err();
      t_restart_on_in1();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule